// File: doc/BRIEF.md
# Prescaled 16-bit Overflow Timer

This block is a free-running 16-bit up-counter steered by one byte-wide control register. The counter advances from one of three sources: a divide-by-12 enable made from the system clock, rising edges of an external count pin, or every clock in a test mode. It can also be halted. The divide-by-12 source and the pin source then pass through a power-of-two prescaler of 1, 2, 4 or 8. All advancing is done through clock enables, so the whole block runs on a single clock.

Two wrap events are tracked. A byte flag marks every wrap of the low eight bits. A word flag marks every wrap of the full count. Each flag has its own interrupt select, and the interrupt output is the OR of the selected flags. A rising edge on an external reset pin can clear the count when the control register enables it. Both pins pass through a synchroniser before their edges are detected.

Software reaches the block through a byte-wide port with one address bit. Address 0 holds the control register. Address 1 holds the word flag. The live counter value is always visible on an output.

Top module: `ovf_timer16`

## Requirements
- R1: After reset the count is 0000, both registers read 00, and the interrupt output is low.
- R2: With mode code 00 (control bits 1:0), the count does not change.
- R3: With mode code 01 the counter advances once every 12·2^p clocks. Here p is the prescale code in control bits 3:2. Counting starts from the control write, so the first step lands 12·2^p clocks after the write edge.
- R4: With mode code 11, each synchronised rising edge of ext_cnt_i is a source event, and the count advances on every 2^p-th event counted from the control write. With p=0 the step lands on the third clock edge after the pin rises.
- R5: With mode code 10, the count advances on every clock after the write and ignores the prescale code.
- R6: When control bit 5 is 1, a synchronised rising edge of ext_rst_i clears the count to 0000, and this takes priority over a step. When the bit is 0, the pin has no effect on the count.
- R7: The byte flag (control bit 4) is set in the clock in which the low byte steps from FF to 00. A control write with bit 4 at 0 clears it.
- R8: The word flag (address 1, bit 0) is set when the count steps from FFFF to 0000. A write to address 1 with bit 0 at 0 clears it, and a write with bit 0 at 1 leaves it unchanged. In the same clock, a hardware set wins over a software clear.
- R9: irq_o is high exactly when the byte flag is set with control bit 6 at 1, or when the word flag is set with control bit 7 at 1.
- R10: Address 0 reads back the last byte written to it, changed only by hardware setting bit 4. Address 1 reads bits 7:1 as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register select: 0 control, 1 word flag |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data for addr_i, combinational |
| ext_cnt_i | input | 1 | External count pin, asynchronous |
| ext_rst_i | input | 1 | External count-reset pin, asynchronous |
| count_o | output | 16 | Live counter value |
| irq_o | output | 1 | Interrupt request |

## Verification
Each result has a fixed due time. A control write takes effect at its own clock edge. A test-mode step then lands on the next edge, and a divided step lands 12·2^p edges later. An edge on either pin acts on the third edge after the pin changes. Flags and the interrupt follow in the same edge as the step that wraps the count. The bench drives and samples on the falling edge and waits an exact number of edges from each write, so every expected value is a closed-form count of edges. Reads are combinational and are sampled one time unit after the address is set.

// File: rtl/ovf_timer_pkg.sv
package ovf_timer_pkg;
  localparam int unsigned PRESC_W = 2;

  typedef enum logic [1:0] {
    MODE_HALT = 2'b00,
    MODE_SYS  = 2'b01,
    MODE_TEST = 2'b10,
    MODE_PIN  = 2'b11
  } src_mode_e;

  typedef struct packed {
    logic               word_ie;
    logic               byte_ie;
    logic               ext_rst_en;
    logic               byte_flag;
    logic [PRESC_W-1:0] presc;
    src_mode_e          mode;
  } ctrl_t;
endpackage

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], d_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/tmr_div_enable.sv
module tmr_div_enable #(
  parameter int unsigned DIV = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i)           cnt_q <= '0;
    else if (cnt_q == LAST)   cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST) & ~clr_i;
endmodule

// File: rtl/tmr_presc_enable.sv
module tmr_presc_enable #(
  parameter int unsigned CODE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              pulse_o
);
  localparam int unsigned CW = (1 << CODE_W) - 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] mask;

  // code n -> low n bits all ones marks the 2^n-th event
  assign mask    = ~({CW{1'b1}} << code_i);
  assign pulse_o = en_i & ((cnt_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (pulse_o) cnt_q <= '0;
    else if (en_i)    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ovf_timer16.sv
module ovf_timer16
  import ovf_timer_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned LOW_W       = 8,
  parameter int unsigned SYS_DIV     = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             addr_i,
  input  logic [7:0]       wr_data_i,
  output logic [7:0]       rd_data_o,
  input  logic             ext_cnt_i,
  input  logic             ext_rst_i,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o
);
  ctrl_t            ctrl_q;
  logic             word_flag_q;
  logic [CNT_W-1:0] cnt_q;

  logic ctrl_wr, stat_wr;
  logic pin_rise, rst_rise, rst_evt;
  logic sys_tick, src_en, presc_pulse, step;
  logic low_wrap, word_wrap;

  assign ctrl_wr = wr_en_i & ~addr_i;
  assign stat_wr = wr_en_i &  addr_i;

  tmr_sync_edge #(.STAGES(SYNC_STAGES)) i_cnt_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(ext_cnt_i), .rise_o(pin_rise)
  );

  tmr_sync_edge #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(ext_rst_i), .rise_o(rst_rise)
  );

  tmr_div_enable #(.DIV(SYS_DIV)) i_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (ctrl_wr | (ctrl_q.mode != MODE_SYS)),
    .tick_o(sys_tick)
  );

  always_comb begin
    unique case (ctrl_q.mode)
      MODE_SYS: src_en = sys_tick;
      MODE_PIN: src_en = pin_rise;
      default:  src_en = 1'b0;
    endcase
  end

  tmr_presc_enable #(.CODE_W(PRESC_W)) i_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (ctrl_wr | (ctrl_q.mode == MODE_HALT)),
    .en_i   (src_en),
    .code_i (ctrl_q.presc),
    .pulse_o(presc_pulse)
  );

  assign rst_evt   = rst_rise & ctrl_q.ext_rst_en;
  assign step      = (ctrl_q.mode == MODE_TEST) | presc_pulse;
  assign low_wrap  = step & ~rst_evt & (cnt_q[LOW_W-1:0] == '1);
  assign word_wrap = step & ~rst_evt & (cnt_q == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (rst_evt) cnt_q <= '0;
    else if (step)    cnt_q <= cnt_q + 1'b1;
  end

  // hardware set placed last so it wins over a write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else begin
      if (ctrl_wr)  ctrl_q <= ctrl_t'(wr_data_i);
      if (low_wrap) ctrl_q.byte_flag <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_flag_q <= 1'b0;
    end else begin
      if (stat_wr && !wr_data_i[0]) word_flag_q <= 1'b0;
      if (word_wrap)                word_flag_q <= 1'b1;
    end
  end

  assign irq_o     = (ctrl_q.byte_flag & ctrl_q.byte_ie) | (word_flag_q & ctrl_q.word_ie);
  assign rd_data_o = addr_i ? {7'b0, word_flag_q} : ctrl_q;
  assign count_o   = cnt_q;
endmodule

// File: rtl/ovf_timer16_chk.sv
module ovf_timer16_chk
  import ovf_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned LOW_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] count_o,
  input logic             irq_o,
  input ctrl_t            ctrl_i,
  input logic             word_flag_i,
  input logic             step_i,
  input logic             rst_evt_i
);
  assert_halt_holds_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.mode == MODE_HALT && !rst_evt_i) |=> $stable(count_o));

  assert_test_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.mode == MODE_TEST && !rst_evt_i) |=> count_o == $past(count_o) + 1'b1);

  assert_ext_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_evt_i |=> count_o == '0);

  assert_byte_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !rst_evt_i && count_o[LOW_W-1:0] == '1) |=> ctrl_i.byte_flag);

  assert_word_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !rst_evt_i && count_o == '1) |=> word_flag_i);

  assert_irq_masked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i.byte_ie && !ctrl_i.word_ie) |-> !irq_o);

  assert_count_moves_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(count_o) |-> (count_o == $past(count_o) + 1'b1 || count_o == '0));
endmodule

bind ovf_timer16 ovf_timer16_chk #(.CNT_W(CNT_W), .LOW_W(LOW_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .count_o    (count_o),
  .irq_o      (irq_o),
  .ctrl_i     (ctrl_q),
  .word_flag_i(word_flag_q),
  .step_i     (step),
  .rst_evt_i  (rst_evt)
);

// File: tb/test_ovf_timer16.sv
module test_ovf_timer16;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        addr = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic        ext_cnt = 1'b0;
  logic        ext_rst = 1'b0;
  logic [15:0] count;
  logic        irq;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  ovf_timer16 i_ovf_timer16 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wr_data_i(wr_data), .rd_data_o(rd_data), .ext_cnt_i(ext_cnt),
    .ext_rst_i(ext_rst), .count_o(count), .irq_o(irq)
  );

  localparam int NV = 9;
  localparam logic [7:0] V_CTRL [NV] = '{8'h21, 8'h25, 8'h29, 8'h2D, 8'h22, 8'h2E, 8'h20, 8'h21, 8'h21};
  localparam int         V_N    [NV] = '{50,    50,    100,   200,   37,    20,    30,    11,    12};
  localparam int         V_EXP  [NV] = '{4,     2,     2,     2,     37,    20,    0,     0,     1};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic pulse_rst();
    ext_rst = 1'b1;
    repeat (4) @(negedge clk);
    ext_rst = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_cnt();
    ext_cnt = 1'b1;
    repeat (2) @(negedge clk);
    ext_cnt = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic zero_count();
    wr(1'b0, 8'h20);
    pulse_rst();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 count", count, 0);
    rd(1'b0, v); chk("R1 ctrl", v, 0);
    rd(1'b1, v); chk("R1 word flag", v, 0);
    chk("R1 irq", irq, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 readback
    wr(1'b0, 8'hC3);
    rd(1'b0, v); chk("R10 ctrl readback", v, 8'hC3);
    wr(1'b1, 8'hFE);
    rd(1'b1, v); chk("R10 status upper zero", v, 8'h00);
    wr(1'b0, 8'h00);

    // vector table: R2 halt, R3 divided, R5 test mode
    for (int i = 0; i < NV; i++) begin
      zero_count();
      wr(1'b0, V_CTRL[i]);
      repeat (V_N[i]) @(negedge clk);
      case (V_CTRL[i][1:0])
        2'b00:   chk("R2 halted count", count, V_EXP[i]);
        2'b01:   chk("R3 divided count", count, V_EXP[i]);
        default: chk("R5 test-mode count", count, V_EXP[i]);
      endcase
    end

    // R4 pin source
    zero_count();
    wr(1'b0, 8'h23);
    repeat (5) pulse_cnt();
    repeat (4) @(negedge clk);
    chk("R4 pin count p0", count, 5);
    zero_count();
    wr(1'b0, 8'h27);
    repeat (6) pulse_cnt();
    repeat (4) @(negedge clk);
    chk("R4 pin count p1", count, 3);

    // R7 byte flag, R9 masking
    zero_count();
    wr(1'b0, 8'h62);
    repeat (255) @(negedge clk);
    chk("R5 count 255", count, 255);
    rd(1'b0, v); chk("R7 flag before wrap", v[4], 0);
    chk("R9 irq before wrap", irq, 0);
    @(negedge clk);
    chk("R7 count after wrap", count, 16'h0100);
    rd(1'b0, v); chk("R7 flag after wrap", v[4], 1);
    chk("R9 byte irq", irq, 1);
    wr(1'b0, 8'h20);
    rd(1'b0, v); chk("R7 flag cleared", v[4], 0);
    chk("R9 irq after clear", irq, 0);
    wr(1'b0, 8'h30);
    chk("R9 flag set, select off", irq, 0);
    wr(1'b0, 8'h70);
    chk("R9 flag set, select on", irq, 1);

    // R6 disabled then enabled
    wr(1'b0, 8'h00);
    pulse_rst();
    chk("R6 disabled keeps count", count, 16'h0101);
    wr(1'b0, 8'h20);
    pulse_rst();
    chk("R6 enabled clears count", count, 0);

    // R8 word flag
    wr(1'b0, 8'h22);
    repeat (65535) @(negedge clk);
    chk("R8 count ffff", count, 16'hFFFF);
    rd(1'b1, v); chk("R8 flag before wrap", v, 0);
    @(negedge clk);
    chk("R8 count wrapped", count, 0);
    rd(1'b1, v); chk("R8 flag after wrap", v, 1);
    chk("R9 word select off", irq, 0);
    wr(1'b0, 8'hA0);
    chk("R9 word irq", irq, 1);
    wr(1'b1, 8'h01);
    rd(1'b1, v); chk("R8 write one keeps flag", v, 1);
    wr(1'b1, 8'h00);
    rd(1'b1, v); chk("R8 write zero clears", v, 0);
    chk("R9 irq after word clear", irq, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule